// File: doc/BRIEF.md
# Misalignment-Aware Load/Store Unit

This block sits between a core's load/store request port and a memory that is one 32-bit word wide. Each request carries a byte address, a size code, a write flag, store data, a byte-order select, a misalignment-policy select and a sign-extension select. The unit classifies each request as aligned or misaligned. Aligned requests become a single word access. Under the trapping policy, a misaligned request is refused with a trap response and never reaches memory. Under the splitting policy, a misaligned request is carried out as two word accesses on consecutive cycles. The bytes of both words are gathered into one operand, or scattered across both words.

The memory port is a simple synchronous one. When `mem_en` is high, a write takes place at the clock edge under per-byte enables. Read data appears on `mem_rdata` in the following cycle. Every accepted request produces exactly one response pulse: a trap, a store completion, or load data in the chosen byte order with zero or sign extension. The policy, byte-order and extension selects belong to the request and are captured with it.

Top module: `lsu_align_unit`

## Requirements
- R1: Size code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 both mean 4 bytes. A request at byte address A with size s is aligned exactly when A mod s is 0, so single-byte requests are never misaligned.
- R2: With `req_split_en`=0, a misaligned request drives no memory access. One cycle after acceptance it produces `rsp_valid`=1 with `rsp_trap`=1 and `rsp_rdata`=0, and memory is left unchanged.
- R3: With `req_split_en`=1, a misaligned request is served by two accesses: first to word A>>2 in the acceptance cycle, then to word (A>>2)+1 in the next cycle. This holds even when all operand bytes lie in the first word. `req_ready` is 0 during the second access, and the response comes one cycle after it.
- R4: An aligned request makes exactly one memory access, in the acceptance cycle, and responds without a trap one cycle later, under either policy.
- R5: With `req_big_endian`=0, operand byte k (k=0 least significant) maps to byte address A+k. Byte address 4w+j sits in lane j, bits 8j+7..8j, of memory word w.
- R6: With `req_big_endian`=1, operand byte s-1-k maps to byte address A+k, so the most significant byte sits at the lowest address.
- R7: A store writes only the s bytes of the operand, using `mem_be` bit j for lane j. Every other byte of both touched words keeps its value.
- R8: Loads of 1 or 2 bytes are zero-extended to 32 bits when `req_sign_ext`=0. They are sign-extended from the operand's most significant bit when `req_sign_ext`=1.
- R9: The policy, byte-order and extension selects are sampled per request. Back-to-back requests with different settings are each handled by their own settings.
- R10: A store completes with `rsp_valid`=1, `rsp_trap`=0 and `rsp_rdata`=0.
- R11: After reset, `rsp_valid` and `mem_en` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | Size code (0:1, 1:2, 2/3:4 bytes) |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 32 | Store operand in its low s bytes |
| req_big_endian | input | 1 | 1 selects big-endian byte order |
| req_split_en | input | 1 | 1 splits misaligned requests, 0 traps them |
| req_sign_ext | input | 1 | 1 sign-extends short loads |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW-2 | Word address |
| mem_be | output | 4 | Per-lane byte enables |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, valid the cycle after an access |
| rsp_valid | output | 1 | Response pulse |
| rsp_trap | output | 1 | Response is a misalignment trap |
| rsp_rdata | output | 32 | Load result (0 for stores and traps) |

## Verification
Each piece of internal state has a visible symptom at the ports. A wrong split state shows up at once: a missing or repeated second word access, or `req_ready` staying low. A wrong captured byte-order, offset or size field corrupts the very next response, with bytes reordered, shifted or wrongly extended. A misbehaving lane-enable path shows up later instead: stray enables clobber neighbouring bytes, and this only becomes visible when those bytes are read back. For that reason the scoreboard keeps a byte-level shadow of memory, and it checks the exact response cycle and the running access count for every request.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int LANES  = 4;
  localparam int WORD_W = 8 * LANES;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic {ST_OPEN, ST_SECOND} lsu_st_e;

  // size code to byte count; codes 2 and 3 both select a full word
  function automatic logic [OFF_W:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return (OFF_W+1)'(1);
      2'd1:    return (OFF_W+1)'(2);
      default: return (OFF_W+1)'(LANES);
    endcase
  endfunction
endpackage

// File: rtl/lsu_rst_sync.sv
module lsu_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_align_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  output logic             misaligned
);
  logic [OFF_W:0] nbytes;
  logic [OFF_W:0] mask;

  always_comb begin
    nbytes     = size_bytes(size);
    mask       = nbytes - 1'b1;
    misaligned = |(off & mask[OFF_W-1:0]);
  end

  // single bytes can never straddle anything
  always_comb begin
    p_byte_aligned_r1: assert (size != 2'd0 || !misaligned);
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_align_pkg::*;
(
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  input  logic              big,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] data_lo,
  output logic [WORD_W-1:0] data_hi,
  output logic [LANES-1:0]  be_lo,
  output logic [LANES-1:0]  be_hi
);
  logic [2*WORD_W-1:0] wide;
  logic [2*LANES-1:0]  be2;
  int                  nb;

  // scatter operand bytes across a two-word window starting at the offset
  always_comb begin
    wide = '0;
    be2  = '0;
    nb   = int'(size_bytes(size));
    for (int j = 0; j < 2*LANES; j++) begin
      int k;
      int src;
      k   = j - int'(off);
      src = big ? (nb - 1 - k) : k;
      if (k >= 0 && k < nb) begin
        wide[8*j +: 8] = wdata[8*src +: 8];
        be2[j]         = 1'b1;
      end
    end
  end

  assign data_lo = wide[WORD_W-1:0];
  assign data_hi = wide[2*WORD_W-1:WORD_W];
  assign be_lo   = be2[LANES-1:0];
  assign be_hi   = be2[2*LANES-1:LANES];

  always_comb begin
    p_be_count_r7: assert ($countones(be2) == nb);
  end
endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge
  import lsu_align_pkg::*;
(
  input  logic [2*WORD_W-1:0] wide,
  input  logic [OFF_W-1:0]    off,
  input  logic [1:0]          size,
  input  logic                big,
  input  logic                sext,
  output logic [WORD_W-1:0]   result
);
  int   nb;
  logic msb;

  // gather bytes from the window, reorder, then extend
  always_comb begin
    result = '0;
    nb     = int'(size_bytes(size));
    for (int k = 0; k < LANES; k++) begin
      int dst;
      dst = big ? (nb - 1 - k) : k;
      if (k < nb) result[8*dst +: 8] = wide[8*(int'(off) + k) +: 8];
    end
    msb = result[8*nb - 1];
    for (int k = 0; k < LANES; k++) begin
      if (k >= nb) result[8*k +: 8] = {8{sext & msb}};
    end
  end

  always_comb begin
    p_zero_ext_r8: assert (sext || size != 2'd0 || result[WORD_W-1:8] == '0);
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              req_big_endian,
  input  logic              req_split_en,
  input  logic              req_sign_ext,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-OFF_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_trap,
  output logic [WORD_W-1:0] rsp_rdata
);
  localparam int WA = AW - OFF_W;
  localparam logic [WA-1:0] WA_ONE = WA'(1);

  logic rst_n_s;
  lsu_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  // request decode
  logic              acc, mis, trap_now, split_now;
  logic [WORD_W-1:0] st_lo, st_hi;
  logic [LANES-1:0]  be_lo, be_hi;
  logic [WA-1:0]     word_a;

  assign word_a = req_addr[AW-1:OFF_W];

  lsu_align_check u_chk (
    .off(req_addr[OFF_W-1:0]), .size(req_size), .misaligned(mis)
  );

  lsu_store_lanes u_st (
    .off(req_addr[OFF_W-1:0]), .size(req_size), .big(req_big_endian),
    .wdata(req_wdata), .data_lo(st_lo), .data_hi(st_hi),
    .be_lo(be_lo), .be_hi(be_hi)
  );

  // state
  lsu_st_e st_q, st_d;
  logic    pend_q, pend_d;

  // captured request fields
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic              big_q, sext_q, wr_q, trap_q, split_q;
  logic [WA-1:0]     hi_addr_q;
  logic [WORD_W-1:0] hi_data_q;
  logic [LANES-1:0]  hi_be_q;
  logic [WORD_W-1:0] rdata0_q;

  assign req_ready = (st_q == ST_OPEN);
  assign acc       = req_valid && req_ready;
  assign trap_now  = acc && mis && !req_split_en;
  assign split_now = acc && mis && req_split_en;

  always_comb begin
    st_d   = split_now ? ST_SECOND : ST_OPEN;
    pend_d = (acc && !split_now) || (st_q == ST_SECOND);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= ST_OPEN;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      off_q     <= req_addr[OFF_W-1:0];
      size_q    <= req_size;
      big_q     <= req_big_endian;
      sext_q    <= req_sign_ext;
      wr_q      <= req_write;
      trap_q    <= trap_now;
      split_q   <= split_now;
      hi_addr_q <= word_a + WA_ONE;
      hi_data_q <= st_hi;
      hi_be_q   <= be_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == ST_SECOND) rdata0_q <= mem_rdata;
  end

  // memory port
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = word_a;
    mem_be    = be_lo;
    mem_wdata = st_lo;
    if (st_q == ST_SECOND) begin
      mem_en    = 1'b1;
      mem_we    = wr_q;
      mem_addr  = hi_addr_q;
      mem_be    = hi_be_q;
      mem_wdata = hi_data_q;
    end else if (acc && !trap_now) begin
      mem_en = 1'b1;
      mem_we = req_write;
    end
  end

  // response
  logic [2*WORD_W-1:0] rd_wide;
  logic [WORD_W-1:0]   ld_val;

  assign rd_wide = split_q ? {mem_rdata, rdata0_q} : {{WORD_W{1'b0}}, mem_rdata};

  lsu_load_merge u_ld (
    .wide(rd_wide), .off(off_q), .size(size_q), .big(big_q),
    .sext(sext_q), .result(ld_val)
  );

  assign rsp_valid = pend_q;
  assign rsp_trap  = pend_q && trap_q;
  assign rsp_rdata = (pend_q && !trap_q && !wr_q) ? ld_val : '0;

  p_trap_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_trap |-> (!$past(mem_en) && rsp_rdata == '0));

  p_second_access_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == ST_SECOND) |-> (mem_en && !req_ready && mem_addr == $past(mem_addr) + WA_ONE));

  p_split_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == ST_SECOND) |=> (rsp_valid && !rsp_trap));

  p_aligned_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_ready && !mis) |=> (rsp_valid && !rsp_trap));
endmodule

// File: tb/lsu_align_unit_tb.sv
module lsu_align_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_big_endian = 1'b0;
  logic        req_split_en = 1'b0, req_sign_ext = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready, mem_en, mem_we, rsp_valid, rsp_trap;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata, rsp_rdata;

  always #2 clk = ~clk;

  lsu_align_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .req_big_endian(req_big_endian),
    .req_split_en(req_split_en), .req_sign_ext(req_sign_ext),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_trap(rsp_trap), .rsp_rdata(rsp_rdata)
  );

  // memory model and independent shadow, 64 bytes each
  logic [7:0] mem_b [64];
  logic [7:0] shadow [64];
  int cyc = 0, acc_cnt = 0, exp_acc = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc++;
    if (mem_en) begin
      acc_cnt++;
      for (int j = 0; j < 4; j++)
        if (mem_we && mem_be[j]) mem_b[4*mem_addr[3:0] + j] <= mem_wdata[8*j +: 8];
      mem_rdata <= {mem_b[4*mem_addr[3:0]+3], mem_b[4*mem_addr[3:0]+2],
                    mem_b[4*mem_addr[3:0]+1], mem_b[4*mem_addr[3:0]]};
    end
  end

  typedef struct {
    bit          trap;
    logic [31:0] data;
    int          cyc;
    int          acc;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic do_req(input int addr, input logic [1:0] sz, input bit we,
                        input logic [31:0] wd, input bit big, input bit split,
                        input bit sext, input string tag);
    exp_t e;
    int   n;
    bit   mis;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n      = nbytes(sz);
    mis    = (addr % n) != 0;
    e.tag  = tag;
    e.trap = mis && !split;
    exp_acc += e.trap ? 0 : (mis ? 2 : 1);
    e.acc  = exp_acc;
    e.cyc  = cyc + ((mis && split) ? 2 : 1);
    e.data = '0;
    if (!e.trap && !we) begin
      for (int k = 0; k < n; k++)
        e.data[8*(big ? n-1-k : k) +: 8] = shadow[(addr + k) % 64];
      if (sext && n < 4 && e.data[8*n-1])
        for (int k = n; k < 4; k++) e.data[8*k +: 8] = 8'hFF;
    end
    if (!e.trap && we)
      for (int k = 0; k < n; k++)
        shadow[(addr + k) % 64] = wd[8*(big ? n-1-k : k) +: 8];
    q.push_back(e);
    req_valid      = 1'b1;
    req_addr       = addr;
    req_size       = sz;
    req_write      = we;
    req_wdata      = wd;
    req_big_endian = big;
    req_split_en   = split;
    req_sign_ext   = sext;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "unexpected response", {31'd0, rsp_trap, rsp_rdata}, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rsp_trap == e.trap && rsp_rdata == e.data, e.tag,
            {31'd0, rsp_trap, rsp_rdata}, {31'd0, e.trap, e.data});
        chk(cyc == e.cyc && acc_cnt == e.acc, {e.tag, " timing/accesses"},
            {32'(cyc), 32'(acc_cnt)}, {32'(e.cyc), 32'(e.acc)});
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem_b[i]  = 8'(i * 37 + 5);
      shadow[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!rsp_valid && !mem_en && req_ready, "R11 reset state",
        {61'd0, rsp_valid, mem_en, req_ready}, 64'd1);

    do_req(0,  2'd2, 0, 0, 0, 0, 0, "R4 R5 aligned word little-endian");
    do_req(4,  2'd2, 0, 0, 1, 0, 0, "R6 aligned word big-endian");
    do_req(10, 2'd1, 0, 0, 0, 0, 1, "R8 half sign-extend");
    do_req(10, 2'd1, 0, 0, 0, 0, 0, "R8 half zero-extend");
    do_req(7,  2'd0, 0, 0, 0, 0, 1, "R1 R8 byte at odd address is aligned");
    do_req(13, 2'd3, 0, 0, 0, 0, 0, "R1 size code 3 misaligned traps");
    do_req(36, 2'd3, 0, 0, 1, 0, 0, "R1 size code 3 aligned");
    do_req(6,  2'd2, 0, 0, 0, 0, 0, "R2 misaligned word traps");
    do_req(3,  2'd1, 0, 0, 0, 0, 0, "R2 misaligned half traps");
    do_req(5,  2'd2, 0, 0, 0, 1, 0, "R3 R5 split word load little-endian");
    do_req(7,  2'd2, 0, 0, 1, 1, 0, "R3 R6 split word load big-endian");
    do_req(1,  2'd1, 0, 0, 0, 1, 1, "R3 split half inside one word");
    do_req(11, 2'd2, 1, 32'hA1B2C3D4, 0, 1, 0, "R7 R10 split word store");
    do_req(8,  2'd2, 0, 0, 0, 0, 0, "R7 neighbour word 8 after store");
    do_req(12, 2'd2, 0, 0, 0, 0, 0, "R7 neighbour word 12 after store");
    do_req(19, 2'd1, 1, 32'h0000_5566, 1, 1, 0, "R7 R6 split half store big-endian");
    do_req(16, 2'd2, 0, 0, 0, 0, 0, "R7 word 16 after half store");
    do_req(20, 2'd2, 0, 0, 0, 0, 0, "R7 word 20 after half store");
    do_req(22, 2'd2, 1, 32'hDEADBEEF, 0, 0, 0, "R2 trapped store");
    do_req(20, 2'd2, 0, 0, 0, 0, 0, "R2 memory unchanged after trapped store");
    do_req(26, 2'd2, 0, 0, 0, 0, 0, "R9 back-to-back trap");
    do_req(26, 2'd2, 0, 0, 0, 1, 0, "R9 back-to-back split");
    do_req(26, 2'd2, 0, 0, 1, 1, 0, "R9 back-to-back big-endian split");
    do_req(33, 2'd0, 1, 32'h0000_00EE, 0, 0, 0, "R10 aligned byte store");
    do_req(32, 2'd2, 0, 0, 1, 0, 0, "R6 R7 word after byte store");
    do_req(33, 2'd0, 0, 0, 0, 0, 1, "R8 byte sign-extend");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R3 R4 all responses returned", 64'(q.size()), 64'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule